// File: doc/BRIEF.md
# Multiply-Step Unit with Y Register

This block carries out a single iteration of a shift-and-add multiplication on each clock edge where its step strobe is high. It keeps a Y register that holds the multiplier bits still to be consumed, and the four integer condition codes (negative, zero, overflow, carry). A controller feeds the running partial product back in on every step, together with the multiplicand. Each step shifts the partial product right and adds the multiplicand when the low bit of Y is set. The bit that drops off the partial product moves into the top of Y.

Y is loaded and read through a plain write port and a read port. A full multiplication loads the multiplier into Y, clears the partial product, runs one step per multiplier bit, and then runs one more step with a zero multiplicand. After that last step the high word of the product is on the result and the low word is in Y. The multiplicand is taken as a signed value and the multiplier as an unsigned value. When the multiplicand's top bit is clear, the pair is therefore the plain unsigned product.

Top module: `mstep_unit`

## Requirements
- R1: After reset, Y, the result and all four condition codes read as zero.
- R2: On an edge where the strobe is low and no Y write is requested, Y, the result and the condition codes keep their values whatever the operand inputs carry.
- R3: A step forms its shifted partial product by moving the input partial product right by one bit and filling the top bit with the XOR of the negative and overflow codes held before that step.
- R4: When bit 0 of Y is 0 the addend of a step is zero, and when it is 1 the addend is the multiplicand.
- R5: A step's result is the shifted partial product plus the addend, modulo 2^W. The flag output's bit 3 (negative) is the result's top bit, and bit 2 (zero) is set when the result is zero. Bit 1 (overflow) is set when both operands share a sign that differs from the result's sign, and bit 0 (carry) is the carry out of the addition.
- R6: A step replaces Y with Y shifted right by one, with the input partial product's bit 0 placed in Y's top bit.
- R7: A Y write loads Y from the write data on that edge and has priority over a step's Y update in the same cycle, while the result and codes still follow the step. The read port always shows the current Y.
- R8: With Y loaded with multiplier M, the partial product starting at zero and codes cleared by reset, W steps with multiplicand A followed by one step with multiplicand zero leave the 2W-bit product of signed A and unsigned M, with the high half on the result and the low half in Y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Perform one multiply step on this edge |
| pp_in | input | DATA_W | Partial product entering the step |
| mcand_in | input | DATA_W | Multiplicand added when Y bit 0 is set |
| y_wr_en | input | 1 | Load Y from y_wr_data on this edge |
| y_wr_data | input | DATA_W | Value loaded into Y |
| y_rd_data | output | DATA_W | Current Y contents |
| result_o | output | DATA_W | Partial product produced by the latest step |
| flags_o | output | 4 | Condition codes: bit 3 negative, bit 2 zero, bit 1 overflow, bit 0 carry |

## Verification
The bench builds the block with DATA_W at 32, a registered result and overflow taken from the carry into the top bit. At this width a full 32-step run with a closing zero-addend step forms a complete 64-bit product split across the result and Y. That puts in reach both the signed-multiplicand case, where the shift-in bit must come from negative XOR overflow rather than the carry, and the all-ones operands. Short hand-picked step chains drive each condition code to both values, including a step that sets overflow and carry together with a zero result.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

   // Condition codes; packed order gives the flag bus layout (3:N 2:Z 1:V 0:C)
   typedef struct packed {
      logic neg;
      logic zero;
      logic ovf;
      logic carry;
   } cc_t;

   localparam int CC_W = $bits(cc_t);

endpackage

// File: rtl/mstep_shift.sv
module mstep_shift
   import mstep_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] pp_i,
   input  logic [W-1:0] mcand_i,
   input  cc_t          cc_i,
   input  logic         y_lsb_i,
   output logic [W-1:0] shifted_o,
   output logic [W-1:0] addend_o,
   output logic         drop_o
);

   logic fill;

   // true sign of the previous sum sits in N^V even when V is set
   assign fill      = cc_i.neg ^ cc_i.ovf;
   assign shifted_o = {fill, pp_i[W-1:1]};
   assign drop_o    = pp_i[0];
   assign addend_o  = y_lsb_i ? mcand_i : '0;

endmodule

// File: rtl/mstep_adder.sv
module mstep_adder
   import mstep_pkg::*;
#(
   parameter int W              = 32,
   parameter bit OVF_FROM_CARRY = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o,
   output cc_t          cc_o
);

   logic [W:0] wide;
   logic       ovf;

   assign wide  = {1'b0, a_i} + {1'b0, b_i};
   assign sum_o = wide[W-1:0];

   generate
      if (OVF_FROM_CARRY) begin : g_ovf_carry
         logic cin_top;
         // carry into the top bit recovered from the top sum bit
         assign cin_top = wide[W-1] ^ a_i[W-1] ^ b_i[W-1];
         assign ovf     = cin_top ^ wide[W];
      end else begin : g_ovf_sign
         assign ovf = (a_i[W-1] == b_i[W-1]) && (wide[W-1] != a_i[W-1]);
      end
   endgenerate

   assign cc_o.neg   = wide[W-1];
   assign cc_o.zero  = ~|wide[W-1:0];
   assign cc_o.ovf   = ovf;
   assign cc_o.carry = wide[W];

endmodule

// File: rtl/mstep_yreg.sv
module mstep_yreg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         shift_en_i,
   input  logic         shift_in_i,
   output logic [W-1:0] y_o
);

   logic [W-1:0] y_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_q <= '0;
      end else if (wr_en_i) begin
         y_q <= wr_data_i;
      end else if (shift_en_i) begin
         y_q <= {shift_in_i, y_q[W-1:1]};
      end
   end

   assign y_o = y_q;

endmodule

// File: rtl/mstep_unit.sv
module mstep_unit
   import mstep_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int OUT_REG        = 1,
   parameter bit OVF_FROM_CARRY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic [DATA_W-1:0] pp_in,
   input  logic [DATA_W-1:0] mcand_in,
   input  logic              y_wr_en,
   input  logic [DATA_W-1:0] y_wr_data,
   output logic [DATA_W-1:0] y_rd_data,
   output logic [DATA_W-1:0] result_o,
   output logic [3:0]        flags_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("mstep_unit: DATA_W must be at least 2");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
         $error("mstep_unit: OUT_REG must be 0 or 1");
      end
   endgenerate

   cc_t               cc_q;
   cc_t               cc_next;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] addend;
   logic [DATA_W-1:0] sum;
   logic              drop_bit;
   logic [DATA_W-1:0] y_cur;

   mstep_shift #(.W(DATA_W)) u_shift (
      .pp_i      (pp_in),
      .mcand_i   (mcand_in),
      .cc_i      (cc_q),
      .y_lsb_i   (y_cur[0]),
      .shifted_o (shifted),
      .addend_o  (addend),
      .drop_o    (drop_bit)
   );

   mstep_adder #(.W(DATA_W), .OVF_FROM_CARRY(OVF_FROM_CARRY)) u_add (
      .a_i   (shifted),
      .b_i   (addend),
      .sum_o (sum),
      .cc_o  (cc_next)
   );

   mstep_yreg #(.W(DATA_W)) u_y (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (y_wr_en),
      .wr_data_i  (y_wr_data),
      .shift_en_i (step_en),
      .shift_in_i (drop_bit),
      .y_o        (y_cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc_q <= '0;
      end else if (step_en) begin
         cc_q <= cc_next;
      end
   end

   generate
      if (OUT_REG == 1) begin : g_res_reg
         logic [DATA_W-1:0] res_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_q <= '0;
            end else if (step_en) begin
               res_q <= sum;
            end
         end
         assign result_o = res_q;
      end else begin : g_res_comb
         assign result_o = sum;
      end
   endgenerate

   assign y_rd_data = y_cur;
   assign flags_o   = cc_q;

endmodule

// File: rtl/mstep_unit_chk.sv
module mstep_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int OUT_REG = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_en,
   input logic [DATA_W-1:0] pp_in,
   input logic              y_wr_en,
   input logic [DATA_W-1:0] y_wr_data,
   input logic [DATA_W-1:0] y_rd_data,
   input logic [DATA_W-1:0] result_o,
   input logic [3:0]        flags_o
);

   // R2: idle edges leave Y and the codes alone
   a_r2_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !y_wr_en) |=> $stable(y_rd_data));

   a_r2_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(flags_o));

   // R7: a write lands in Y on the next edge
   a_r7_y_write: assert property (@(posedge clk) disable iff (!rst_n)
      y_wr_en |=> (y_rd_data == $past(y_wr_data)));

   // R6: a step without a write shifts the dropped bit into Y's top
   a_r6_y_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !y_wr_en) |=>
         (y_rd_data == {$past(pp_in[0]), $past(y_rd_data[DATA_W-1:1])}));

   generate
      if (OUT_REG == 1) begin : g_res_checks
         // R5: zero and negative codes agree with the registered result
         a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
            step_en |=> (flags_o[2] == (result_o == '0)));
         a_r5_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
            step_en |=> (flags_o[3] == result_o[DATA_W-1]));
         // R2: the result holds without a strobe
         a_r2_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !step_en |=> $stable(result_o));
      end
   endgenerate

endmodule

bind mstep_unit mstep_unit_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step_en   (step_en),
   .pp_in     (pp_in),
   .y_wr_en   (y_wr_en),
   .y_wr_data (y_wr_data),
   .y_rd_data (y_rd_data),
   .result_o  (result_o),
   .flags_o   (flags_o)
);

// File: tb/tb_mstep_unit.sv
module tb_mstep_unit;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         step_en = 1'b0;
   logic [W-1:0] pp_in = '0;
   logic [W-1:0] mcand_in = '0;
   logic         y_wr_en = 1'b0;
   logic [W-1:0] y_wr_data = '0;
   logic [W-1:0] y_rd_data;
   logic [W-1:0] result_o;
   logic [3:0]   flags_o;

   mstep_unit #(.DATA_W(W), .OUT_REG(1), .OVF_FROM_CARRY(1'b1)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (step_en),
      .pp_in     (pp_in),
      .mcand_in  (mcand_in),
      .y_wr_en   (y_wr_en),
      .y_wr_data (y_wr_data),
      .y_rd_data (y_rd_data),
      .result_o  (result_o),
      .flags_o   (flags_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      string        tag;
      logic [W-1:0] res;
      logic [3:0]   cc;
      logic [W-1:0] y;
   } exp_t;

   exp_t sb[$];
   int   n_vec = 0;
   int   n_bad = 0;
   logic done = 1'b0;

   // expectation model, built from the requirement text
   logic [W-1:0] m_y   = '0;
   logic [W-1:0] m_res = '0;
   logic [3:0]   m_cc  = '0;

   // monitor: compare queued expectations just after each edge
   exp_t got;
   always begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
         got = sb.pop_front();
         n_vec++;
         if (result_o !== got.res || flags_o !== got.cc || y_rd_data !== got.y) begin
            n_bad++;
            $display("FAIL %s: res=%h cc=%b y=%h expected res=%h cc=%b y=%h",
                     got.tag, result_o, flags_o, y_rd_data, got.res, got.cc, got.y);
         end
      end
   end

   task automatic cycle(input logic st, input logic [W-1:0] pp, input logic [W-1:0] mc,
                        input logic wr, input logic [W-1:0] wd, input string tag);
      logic         fill;
      logic [W-1:0] sh;
      logic [W-1:0] add;
      logic [W:0]   wide;
      logic [W-1:0] ny;
      exp_t         e;
      @(negedge clk);
      step_en   = st;
      pp_in     = pp;
      mcand_in  = mc;
      y_wr_en   = wr;
      y_wr_data = wd;
      ny = m_y;
      if (st) begin
         fill = m_cc[3] ^ m_cc[1];                  // R3
         sh   = {fill, pp[W-1:1]};
         add  = m_y[0] ? mc : '0;                   // R4
         wide = {1'b0, sh} + {1'b0, add};           // R5
         m_res = wide[W-1:0];
         m_cc  = {wide[W-1], (wide[W-1:0] == '0),
                  (sh[W-1] == add[W-1]) && (wide[W-1] != sh[W-1]), wide[W]};
         ny = {pp[0], m_y[W-1:1]};                  // R6
      end
      if (wr) ny = wd;                              // R7
      m_y = ny;
      e.tag = tag; e.res = m_res; e.cc = m_cc; e.y = m_y;
      sb.push_back(e);
      @(posedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      step_en = 1'b0;
      y_wr_en = 1'b0;
      m_y = '0; m_res = '0; m_cc = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R8: full product through W steps plus a closing zero-addend step
   task automatic multiply(input logic [W-1:0] a, input logic [W-1:0] m);
      logic [2*W-1:0] ref_p;
      logic [2*W-1:0] got_p;
      do_reset();
      cycle(1'b0, '0, '0, 1'b1, m, "R7 load multiplier");
      cycle(1'b1, '0, a, 1'b0, '0, "R8 first step");
      for (int i = 1; i < W; i++) begin
         cycle(1'b1, m_res, a, 1'b0, '0, "R8 step");
      end
      cycle(1'b1, m_res, '0, 1'b0, '0, "R8 closing step");
      #2;
      ref_p = $signed({{W{a[W-1]}}, a}) * $signed({{W{1'b0}}, m});
      got_p = {result_o, y_rd_data};
      n_vec++;
      if (got_p !== ref_p) begin
         n_bad++;
         $display("FAIL R8 product %h x %h: got %h expected %h", a, m, got_p, ref_p);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      cycle(1'b0, '0, '0, 1'b0, '0, "R1 reset state");
      cycle(1'b0, 32'hDEADBEEF, 32'h00001234, 1'b0, '0, "R2 idle with busy inputs");
      cycle(1'b0, '0, '0, 1'b1, 32'hA5A5A5A4, "R7 write Y");
      cycle(1'b1, 32'h12345679, 32'hFFFFFFFF, 1'b0, '0, "R4 R6 gated addend");
      cycle(1'b0, '0, '0, 1'b1, 32'h00000001, "R7 write Y lsb set");
      cycle(1'b1, 32'h00000021, 32'h80000000, 1'b0, '0, "R4 R5 negative no overflow");
      cycle(1'b0, '0, '0, 1'b1, 32'hFFFFFFFF, "R7 write Y ones");
      cycle(1'b1, 32'h00000000, 32'h80000000, 1'b0, '0, "R3 R5 fill from N^V, zero carry overflow");
      cycle(1'b1, 32'h00000001, 32'h7FFFFFFF, 1'b0, '0, "R3 R5 fill after overflow");
      cycle(1'b1, 32'hFFFFFFFE, 32'h00000001, 1'b0, '0, "R5 R6 wrap to zero");
      cycle(1'b0, 32'h55555555, 32'hAAAAAAAA, 1'b0, '0, "R2 hold one");
      cycle(1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, '0, "R2 hold two");
      cycle(1'b1, 32'h0F0F0F0F, 32'h11111111, 1'b1, 32'h55AA55AA, "R7 write wins over step");
      cycle(1'b1, 32'h0000FFFF, 32'h00000003, 1'b0, '0, "R4 R6 after write");
      multiply(32'h00000003, 32'h00000005);
      multiply(32'h7FFFFFFF, 32'hFFFFFFFF);
      multiply(32'h12345678, 32'h9ABCDEF0);
      multiply(32'hFFFFFFFF, 32'hFFFFFFFF);
      multiply(32'h80000000, 32'h00000002);
      multiply(32'h00000000, 32'hFFFFFFFF);
      @(negedge clk);
      step_en = 1'b0;
      y_wr_en = 1'b0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule